// File: doc/BRIEF.md
# Serial Port Status, Control and Interrupt Masking

This block holds the control, status and interrupt-enable state that sits around a byte-wide serial transmitter and receiver. Software reaches it through a small register port. It uses a control word to start transmit and receive and to discard a pending transmit byte. It reads a status word that reports how full the buffers are and which receive errors occurred. It programs an enable word that selects which status flags reach the single interrupt line. The serial bit timing and the shift registers sit outside this block. They connect through a load strobe and a done pulse on the transmit side and through a byte-valid strobe with error qualifiers on the receive side.

The transmit side has two stages: a holding buffer and a shifter. Each stage has its own empty flag and its own interrupt enable. Software can therefore refill the buffer as soon as it drains, and it can also learn when the last byte has fully left the shifter. On the receive side, reading the received byte clears the full flag and all receive error flags, including a summary error flag. A second copy of the error flags stays set until software writes zero to it.

Top module: `uart_stat_irq`

## Requirements
- R1: After reset the status word reads 0x03: transmit buffer empty (bit 0) and transmit shifter empty (bit 1) are set and bits 2..7 are clear. The control word, the enable word and irq_o are all zero.
- R2: A write to the transmit data address (4) while bit 0 is set stores the byte and clears bit 0. A write while bit 0 is clear is ignored, and the stored byte is kept.
- R3: While control bit 0 (transmit enable) is set, the buffer holds a byte and the shifter is empty, the byte moves to the shifter on the next edge. tx_start_o then pulses for one cycle with the byte on tx_byte_o, status bit 0 sets and status bit 1 clears. With control bit 0 clear, nothing moves.
- R4: A tx_done_i pulse while the shifter is busy sets status bit 1 again. Bits 0 and 1 both set means the transmit path is idle.
- R5: A control write with bit 2 set discards the buffered byte: bit 0 sets and no byte is sent. Control bit 2 always reads back as 0.
- R6: While control bit 1 (receive enable) is set and status bit 2 (receive full) is clear, rx_valid_i captures rx_byte_i. It sets bit 2, and it loads bit 3 from rx_par_err_i and bit 4 from rx_frm_err_i. With control bit 1 clear, rx_valid_i is ignored.
- R7: A byte that arrives while bit 2 is set sets overrun (bit 5). The byte received earlier is kept.
- R8: Summary error (bit 6) is set exactly when any of bits 3, 4 or 5 is set.
- R9: A read of the receive data address (5) returns the held byte and clears status bits 2 through 6.
- R10: The error copy at address 3 sets bits 3..6 together with the status word. A receive data read does not clear it. A write of zero clears it, and a nonzero write has no effect.
- R11: Only bits 0, 1, 2 and 6 of the enable word (address 2) are writable. The other bits read 0.
- R12: irq_o equals the OR of (status AND enable), delayed by one clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (side effects at the edge) |
| reg_addr_i | input | 3 | Register address: 0 control, 1 status, 2 enable, 3 error copy, 4 transmit data, 5 receive data |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, combinational from the address |
| tx_start_o | output | 1 | One-cycle load strobe to the shifter |
| tx_byte_o | output | 8 | Byte handed to the shifter |
| tx_done_i | input | 1 | Shifter finished its byte |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_byte_i | input | 8 | Received byte |
| rx_par_err_i | input | 1 | Parity error on this byte |
| rx_frm_err_i | input | 1 | Framing error on this byte |
| irq_o | output | 1 | Registered interrupt |

## Verification
Most internal faults show up in the status word on the next read, one edge after the stimulus. A stuck buffer-full state shows as bit 0 staying clear and as tx_start_o never pulsing. A lost shifter-busy state shows as a second load strobe, or as bit 1 set while a byte is still in flight. Receive faults show as a wrong byte returned after an overrun, or as error bits that survive a receive data read. A wrong enable or gating path shows on irq_o exactly one edge after the status or enable change.

// File: rtl/uart_stat_pkg.sv
package uart_stat_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd1;
  localparam logic [ADDR_W-1:0] A_MASK = 3'd2;
  localparam logic [ADDR_W-1:0] A_ERRC = 3'd3;
  localparam logic [ADDR_W-1:0] A_TXD  = 3'd4;
  localparam logic [ADDR_W-1:0] A_RXD  = 3'd5;

  localparam int unsigned B_TBE  = 0;
  localparam int unsigned B_TSBE = 1;
  localparam int unsigned B_RBF  = 2;
  localparam int unsigned B_PER  = 3;
  localparam int unsigned B_FER  = 4;
  localparam int unsigned B_OVR  = 5;
  localparam int unsigned B_SUM  = 6;

  localparam int unsigned C_TXEN  = 0;
  localparam int unsigned C_RXEN  = 1;
  localparam int unsigned C_FLUSH = 2;

  localparam logic [DATA_W-1:0] MASK_WR_BITS = 8'h47;
  localparam int unsigned ERR_W = 4;

  typedef struct packed {
    logic rx_en;
    logic tx_en;
  } ctrl_t;
endpackage

// File: rtl/uart_tx_path.sv
module uart_tx_path #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tx_en_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          flush_i,
  input  logic          done_i,
  output logic          tbe_o,
  output logic          tsbe_o,
  output logic          start_o,
  output logic [DW-1:0] byte_o
);
  logic          buf_full_q;
  logic [DW-1:0] buf_q;
  logic          busy_q;
  logic          load;

  assign load = tx_en_i & buf_full_q & ~busy_q & ~flush_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_full_q <= 1'b0;
      buf_q      <= '0;
    end else if (flush_i || load) begin
      buf_full_q <= 1'b0;
    end else if (wr_i && !buf_full_q) begin
      buf_full_q <= 1'b1;
      buf_q      <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      start_o <= 1'b0;
      byte_o  <= '0;
    end else begin
      start_o <= load;
      if (load) begin
        busy_q <= 1'b1;
        byte_o <= buf_q;
      end else if (done_i) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign tbe_o  = ~buf_full_q;
  assign tsbe_o = ~busy_q;
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_en_i,
  input  logic          valid_i,
  input  logic [DW-1:0] byte_i,
  input  logic          per_i,
  input  logic          fer_i,
  input  logic          rd_clr_i,
  output logic          rbf_o,
  output logic          per_o,
  output logic          fer_o,
  output logic          ovr_o,
  output logic          sum_o,
  output logic [DW-1:0] data_o,
  output logic [3:0]    err_set_o
);
  logic rbf_eff, take, cap, ovf;

  assign rbf_eff = rbf_o & ~rd_clr_i;   // read clears before a same-cycle arrival
  assign take    = rx_en_i & valid_i;
  assign cap     = take & ~rbf_eff;
  assign ovf     = take & rbf_eff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbf_o  <= 1'b0;
      per_o  <= 1'b0;
      fer_o  <= 1'b0;
      ovr_o  <= 1'b0;
      sum_o  <= 1'b0;
      data_o <= '0;
    end else begin
      if (rd_clr_i) begin
        rbf_o <= 1'b0;
        per_o <= 1'b0;
        fer_o <= 1'b0;
        ovr_o <= 1'b0;
        sum_o <= 1'b0;
      end
      if (cap) begin
        rbf_o  <= 1'b1;
        data_o <= byte_i;
        per_o  <= per_i;
        fer_o  <= fer_i;
        if (per_i || fer_i) sum_o <= 1'b1;
      end else if (ovf) begin
        ovr_o <= 1'b1;
        sum_o <= 1'b1;
      end
    end
  end

  // set events in copy order: per, fer, ovr, sum
  assign err_set_o = {(cap & (per_i | fer_i)) | ovf, ovf, cap & fer_i, cap & per_i};
endmodule

// File: rtl/uart_err_copy.sv
module uart_err_copy #(
  parameter int unsigned EW = 4,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [EW-1:0] set_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [EW-1:0] copy_o
);
  logic clr;
  assign clr = wr_i & (wdata_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  copy_o <= '0;
    else if (clr) copy_o <= set_i;
    else          copy_o <= copy_o | set_i;
  end
endmodule

// File: rtl/uart_irq_gen.sv
module uart_irq_gen #(
  parameter int unsigned       DW  = 8,
  parameter logic [DW-1:0]     SRC = 8'h47
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] stat_i,
  input  logic [DW-1:0] mask_i,
  output logic          irq_o
);
  logic [DW-1:0] hit;

  for (genvar i = 0; i < DW; i++) begin : g_src
    if (SRC[i]) begin : g_on
      assign hit[i] = stat_i[i] & mask_i[i];
    end else begin : g_off
      assign hit[i] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |hit;
  end
endmodule

// File: rtl/uart_stat_irq.sv
module uart_stat_irq
  import uart_stat_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              tx_start_o,
  output logic [DATA_W-1:0] tx_byte_o,
  input  logic              tx_done_i,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_byte_i,
  input  logic              rx_par_err_i,
  input  logic              rx_frm_err_i,
  output logic              irq_o
);
  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] mask_q;
  logic [DATA_W-1:0] stat_w;
  logic [DATA_W-1:0] rx_data;
  logic [ERR_W-1:0]  err_set, err_copy;
  logic tbe, tsbe, rbf, per, fer, ovr, sum;
  logic wr_ctrl, wr_mask, wr_errc, wr_txd, rd_rxd, flush;

  assign wr_ctrl = reg_wr_i & (reg_addr_i == A_CTRL);
  assign wr_mask = reg_wr_i & (reg_addr_i == A_MASK);
  assign wr_errc = reg_wr_i & (reg_addr_i == A_ERRC);
  assign wr_txd  = reg_wr_i & (reg_addr_i == A_TXD);
  assign rd_rxd  = reg_rd_i & (reg_addr_i == A_RXD);
  assign flush   = wr_ctrl & reg_wdata_i[C_FLUSH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      mask_q <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.tx_en <= reg_wdata_i[C_TXEN];
        ctrl_q.rx_en <= reg_wdata_i[C_RXEN];
      end
      if (wr_mask) mask_q <= reg_wdata_i & MASK_WR_BITS;
    end
  end

  uart_tx_path #(.DW(DATA_W)) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tx_en_i (ctrl_q.tx_en),
    .wr_i    (wr_txd),
    .wdata_i (reg_wdata_i),
    .flush_i (flush),
    .done_i  (tx_done_i),
    .tbe_o   (tbe),
    .tsbe_o  (tsbe),
    .start_o (tx_start_o),
    .byte_o  (tx_byte_o)
  );

  uart_rx_status #(.DW(DATA_W)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rx_en_i   (ctrl_q.rx_en),
    .valid_i   (rx_valid_i),
    .byte_i    (rx_byte_i),
    .per_i     (rx_par_err_i),
    .fer_i     (rx_frm_err_i),
    .rd_clr_i  (rd_rxd),
    .rbf_o     (rbf),
    .per_o     (per),
    .fer_o     (fer),
    .ovr_o     (ovr),
    .sum_o     (sum),
    .data_o    (rx_data),
    .err_set_o (err_set)
  );

  uart_err_copy #(.EW(ERR_W), .DW(DATA_W)) u_errc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (err_set),
    .wr_i    (wr_errc),
    .wdata_i (reg_wdata_i),
    .copy_o  (err_copy)
  );

  assign stat_w = {1'b0, sum, ovr, fer, per, rbf, tsbe, tbe};

  uart_irq_gen #(.DW(DATA_W), .SRC(MASK_WR_BITS)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stat_i (stat_w),
    .mask_i (mask_q),
    .irq_o  (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      A_CTRL:  reg_rdata_o = {6'b0, ctrl_q.rx_en, ctrl_q.tx_en};
      A_STAT:  reg_rdata_o = stat_w;
      A_MASK:  reg_rdata_o = mask_q;
      A_ERRC:  reg_rdata_o = {1'b0, err_copy, 3'b0};
      A_RXD:   reg_rdata_o = rx_data;
      default: reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/uart_stat_irq_chk.sv
module uart_stat_irq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] stat_i,
  input logic [7:0] mask_i,
  input logic       irq_i,
  input logic       tx_start_i,
  input logic       rx_valid_i,
  input logic       rx_en_i,
  input logic       rxd_rd_i
);
  AST_START_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_i |-> (stat_i[0] && !stat_i[1])); // R3
  AST_START_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_i |=> !tx_start_i); // R3
  AST_OVR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_i[2] && rx_valid_i && rx_en_i && !rxd_rd_i) |=> (stat_i[5] && stat_i[2])); // R7
  AST_SUM_OR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_i[6] == (stat_i[3] | stat_i[4] | stat_i[5])); // R8
  AST_RD_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rxd_rd_i && !rx_valid_i) |=> (stat_i[6:2] == 5'b0)); // R9
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i == 8'h00) |=> !irq_i); // R12
endmodule

bind uart_stat_irq uart_stat_irq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .stat_i     (stat_w),
  .mask_i     (mask_q),
  .irq_i      (irq_o),
  .tx_start_i (tx_start_o),
  .rx_valid_i (rx_valid_i),
  .rx_en_i    (ctrl_q.rx_en),
  .rxd_rd_i   (rd_rxd)
);

// File: tb/sim_uart_stat_irq.sv
`timescale 1ns/1ps
module sim_uart_stat_irq;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       reg_wr_i = 1'b0, reg_rd_i = 1'b0;
  logic [2:0] reg_addr_i = '0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic       tx_start_o;
  logic [7:0] tx_byte_o;
  logic       tx_done_i = 1'b0;
  logic       rx_valid_i = 1'b0;
  logic [7:0] rx_byte_i = '0;
  logic       rx_par_err_i = 1'b0, rx_frm_err_i = 1'b0;
  logic       irq_o;
  int checks = 0, failures = 0;
  logic [7:0] rv;

  always #10 clk_i = ~clk_i;

  uart_stat_irq u0 (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks enter and leave at a falling edge, consuming one rising edge each
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_rd_i = 1'b1; reg_addr_i = a;
    #1 d = reg_rdata_o;
    @(negedge clk_i);
    reg_rd_i = 1'b0;
  endtask

  task automatic rx(input logic [7:0] b, input logic pe, input logic fe);
    rx_valid_i = 1'b1; rx_byte_i = b; rx_par_err_i = pe; rx_frm_err_i = fe;
    @(negedge clk_i);
    rx_valid_i = 1'b0; rx_par_err_i = 1'b0; rx_frm_err_i = 1'b0;
  endtask

  task automatic t_reset();
    rd(3'd1, rv); chk("R1 status", rv, 8'h03);
    rd(3'd0, rv); chk("R1 ctrl", rv, 8'h00);
    rd(3'd2, rv); chk("R1 mask", rv, 8'h00);
    chk("R1 irq", {7'b0, irq_o}, 8'h00);
  endtask

  task automatic t_mask();
    wr(3'd2, 8'hFF);
    rd(3'd2, rv); chk("R11 mask readback", rv, 8'h47);
    chk("R12 irq from tbe", {7'b0, irq_o}, 8'h01);
    wr(3'd2, 8'h00);
    @(negedge clk_i);
    chk("R12 irq masked", {7'b0, irq_o}, 8'h00);
  endtask

  task automatic t_tx();
    wr(3'd4, 8'hA5);
    rd(3'd1, rv); chk("R2 tbe cleared", rv, 8'h02);
    wr(3'd4, 8'h3C);
    @(negedge clk_i);
    chk("R3 disabled no start", {7'b0, tx_start_o}, 8'h00);
    rd(3'd1, rv); chk("R3 disabled holds", rv, 8'h02);
    wr(3'd0, 8'h01);
    @(negedge clk_i);
    chk("R3 start pulse", {7'b0, tx_start_o}, 8'h01);
    chk("R2 first byte kept", tx_byte_o, 8'hA5);
    rd(3'd1, rv); chk("R3 buffer to shifter", rv, 8'h01);
    chk("R3 single pulse", {7'b0, tx_start_o}, 8'h00);
    tx_done_i = 1'b1; @(negedge clk_i); tx_done_i = 1'b0;
    rd(3'd1, rv); chk("R4 idle after done", rv, 8'h03);
  endtask

  task automatic t_flush();
    wr(3'd0, 8'h00);
    wr(3'd4, 8'h11);
    rd(3'd1, rv); chk("R5 buffered", rv, 8'h02);
    wr(3'd0, 8'h04);
    rd(3'd1, rv); chk("R5 flushed", rv, 8'h03);
    rd(3'd0, rv); chk("R5 flush bit reads 0", rv, 8'h00);
    wr(3'd0, 8'h01);
    @(negedge clk_i);
    chk("R5 nothing sent", {7'b0, tx_start_o}, 8'h00);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_rx();
    rx(8'h55, 1'b0, 1'b0);
    rd(3'd1, rv); chk("R6 rx disabled ignored", rv, 8'h03);
    wr(3'd0, 8'h02);
    rx(8'h5A, 1'b0, 1'b0);
    rd(3'd1, rv); chk("R6 rbf set", rv, 8'h07);
    rx(8'h77, 1'b1, 1'b0);
    rd(3'd1, rv); chk("R7 R8 overrun and summary", rv, 8'h67);
    rd(3'd5, rv); chk("R7 earlier byte kept", rv, 8'h5A);
    rd(3'd1, rv); chk("R9 read clears", rv, 8'h03);
    rd(3'd3, rv); chk("R10 copy survives read", rv, 8'h60);
    rx(8'h81, 1'b0, 1'b1);
    rd(3'd1, rv); chk("R6 R8 framing error", rv, 8'h57);
    rd(3'd3, rv); chk("R10 copy accumulates", rv, 8'h70);
    rd(3'd5, rv); chk("R9 byte returned", rv, 8'h81);
    wr(3'd3, 8'h10);
    rd(3'd3, rv); chk("R10 nonzero write no effect", rv, 8'h70);
    wr(3'd3, 8'h00);
    rd(3'd3, rv); chk("R10 zero write clears", rv, 8'h00);
  endtask

  task automatic t_irq_rx();
    wr(3'd2, 8'h04);
    @(negedge clk_i);
    chk("R12 no irq while empty", {7'b0, irq_o}, 8'h00);
    rx(8'h3E, 1'b0, 1'b0);
    chk("R12 irq not yet", {7'b0, irq_o}, 8'h00);
    @(negedge clk_i);
    chk("R12 irq on rbf", {7'b0, irq_o}, 8'h01);
    rd(3'd5, rv); chk("R9 irq byte", rv, 8'h3E);
    @(negedge clk_i);
    chk("R12 irq drops", {7'b0, irq_o}, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_mask();
    t_tx();
    t_flush();
    t_rx();
    t_irq_rx();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule